// File: doc/BRIEF.md
# Sensor Core Run-State and Pad Enable Control

This block holds the control word that decides whether an image sensor's digital core runs, sits in soft reset, restarts its frame sequence or asks for low power. It also decides whether the video output pads are driven. Software writes the word through a simple write strobe and reads it back on a parallel bus. An external standby pin and the programmed integration time are the only other inputs.

The reset bit is sticky and exempt from its own effect. While it is set, it drives a soft reset to the rest of the chip, holds the frame logic idle, and keeps every other bit of the word at its power-up value. The restart bit is a write-one trigger. It yields a single-cycle restart pulse and then holds off valid frames for the integration time. The pad enable is registered. It combines an explicit disable bit with the standby pin, and an override bit can remove the pin from that decision.

Top module: `sensor_ctrl_reg`

## Requirements
- R1: The reset flag sits in bit 0 of the control word. A write stores it at the next clock edge, and from then on `soft_rst` and `rd_data[0]` follow it. Hard reset (`rst_n` low) clears every bit and drives all outputs low.
- R2: While the stored reset flag is 1, bits 2 to 5 read 0 and writes to them are discarded. A write that sets bit 0 also forces bits 2 to 5 to 0. The reset flag itself keeps the value written.
- R3: Writing 0 to bit 0 clears the reset flag. Bits 2 to 5 are then writable again from the following write.
- R4: Writing 1 to bit 1 (restart) raises `restart_pulse` for exactly one cycle, starting at the edge that takes the write. Bit 1 always reads 0.
- R5: A restart write is ignored if the stored reset flag is 1 or if the same write sets bit 0.
- R6: `frame_hold` is high while the reset flag is set. After an accepted restart it is also high for exactly `integ_time` cycles, starting with the pulse cycle. A value of 0 gives no hold.
- R7: Bit 2 (standby) drives `lowpower_req`.
- R8: Bit 3 is a spare. It stores and reads back its value, and it changes no output.
- R9: `pad_oe` is registered. One cycle after the word and pin settle, it equals NOT bit 4 (output disable) AND NOT (`standby_pin` AND NOT bit 5).
- R10: When bit 5 (drive override) is 1, `standby_pin` has no effect on `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | DW | Control word value to write |
| standby_pin | input | 1 | External standby pin |
| integ_time | input | IW | Integration time in cycles, used after a restart |
| rd_data | output | DW | Control word read-back |
| soft_rst | output | 1 | Soft reset to the other registers |
| restart_pulse | output | 1 | One-cycle frame restart strobe |
| lowpower_req | output | 1 | Low-power state request |
| pad_oe | output | 1 | Output enable for the video pads |
| frame_hold | output | 1 | Holds frame output idle or invalid |

## Verification
The bench builds the block with a 16-bit word and an 8-bit integration time. Integration times of 0 and 5 then reach both the no-hold case and the counted hold-off in a few cycles. An 8-bit width also lets a near-maximum value reload the counter during a second restart. The narrow counter keeps the hold window short, so the bench can count it edge by edge against the requirement.

// File: rtl/sensor_ctrl_reg.sv
module sensor_ctrl_reg #(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          standby_pin,
  input  logic [IW-1:0] integ_time,
  output logic [DW-1:0] rd_data,
  output logic          soft_rst,
  output logic          restart_pulse,
  output logic          lowpower_req,
  output logic          pad_oe,
  output logic          frame_hold
);
  localparam int B_RST = 0;
  localparam int B_GO  = 1;
  localparam int B_SBY = 2;
  localparam int B_SPR = 3;
  localparam int B_DIS = 4;
  localparam int B_DRV = 5;
  localparam int USED  = 6;

  logic          rst_q, sby_q, spr_q, dis_q, drv_q, go_q, oe_q;
  logic [IW-1:0] cnt_q;

  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:USED];

  wire set_rst  = wr_en && wr_data[B_RST];
  wire to_dflt  = rst_q || set_rst;
  wire take     = wr_en && !to_dflt;
  wire go       = take && wr_data[B_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else if (wr_en) rst_q <= wr_data[B_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sby_q <= 1'b0; spr_q <= 1'b0; dis_q <= 1'b0; drv_q <= 1'b0;
    end else if (to_dflt) begin
      sby_q <= 1'b0; spr_q <= 1'b0; dis_q <= 1'b0; drv_q <= 1'b0;
    end else if (take) begin
      sby_q <= wr_data[B_SBY];
      spr_q <= wr_data[B_SPR];
      dis_q <= wr_data[B_DIS];
      drv_q <= wr_data[B_DRV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (to_dflt)       cnt_q <= '0;
    else if (go)            cnt_q <= integ_time;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= !dis_q && !(standby_pin && !drv_q);
  end

  always_comb begin
    rd_data        = '0;
    rd_data[B_RST] = rst_q;
    rd_data[B_SBY] = sby_q;
    rd_data[B_SPR] = spr_q;
    rd_data[B_DIS] = dis_q;
    rd_data[B_DRV] = drv_q;
  end

  assign soft_rst      = rst_q;
  assign restart_pulse = go_q;
  assign lowpower_req  = sby_q;
  assign pad_oe        = oe_q;
  assign frame_hold    = rst_q || (cnt_q != '0);
endmodule

module sensor_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       restart_pulse,
  input logic       frame_hold,
  input logic       pad_oe,
  input logic       standby_pin,
  input logic [3:0] cfg
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);

  assert_no_restart_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    restart_pulse |-> (!soft_rst && !$past(soft_rst)));

  assert_defaults_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (cfg == 4'b0000));

  assert_hold_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> frame_hold);

  assert_oe_rule_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pad_oe == (!$past(cfg[2]) && !($past(standby_pin) && !$past(cfg[3]))));
endmodule

bind sensor_ctrl_reg sensor_ctrl_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .restart_pulse(restart_pulse),
  .frame_hold(frame_hold), .pad_oe(pad_oe), .standby_pin(standby_pin),
  .cfg(rd_data[5:2])
);

// File: tb/sensor_ctrl_reg_tb.sv
module sensor_ctrl_reg_tb_top;
  localparam int DW = 16;
  localparam int IW = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, standby_pin = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] integ_time = '0;
  logic [DW-1:0] rd_data;
  logic soft_rst, restart_pulse, lowpower_req, pad_oe, frame_hold;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sensor_ctrl_reg #(.DW(DW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .standby_pin(standby_pin), .integ_time(integ_time), .rd_data(rd_data),
    .soft_rst(soft_rst), .restart_pulse(restart_pulse), .lowpower_req(lowpower_req),
    .pad_oe(pad_oe), .frame_hold(frame_hold));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_hard_reset();
    chk(rd_data == 0 && !soft_rst && !restart_pulse && !pad_oe && !frame_hold,
        "R1 hard reset", {rd_data, soft_rst, pad_oe}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(pad_oe == 1'b1, "R9 oe after reset", pad_oe, 1);
  endtask

  task automatic t_spare_standby();
    wr(16'h000C);
    chk(rd_data == 16'h000C, "R8 spare readback", rd_data, 16'h000C);
    chk(lowpower_req == 1'b1, "R7 lowpower", lowpower_req, 1);
    chk(!soft_rst && !frame_hold && !restart_pulse, "R8 spare no effect",
        {soft_rst, frame_hold, restart_pulse}, 0);
    wr(16'h0008);
    chk(lowpower_req == 1'b0 && rd_data == 16'h0008, "R7 lowpower clear", rd_data, 16'h0008);
    wr(16'h0000);
  endtask

  task automatic t_oe();
    wr(16'h0010);
    chk(pad_oe == 1'b1, "R9 oe lags one cycle", pad_oe, 1);
    @(negedge clk);
    chk(pad_oe == 1'b0, "R9 disable", pad_oe, 0);
    wr(16'h0000);
    @(negedge clk);
    standby_pin = 1'b1;
    @(negedge clk);
    chk(pad_oe == 1'b0, "R9 standby pin", pad_oe, 0);
    wr(16'h0020);
    @(negedge clk);
    chk(pad_oe == 1'b1, "R10 override", pad_oe, 1);
    wr(16'h0030);
    @(negedge clk);
    chk(pad_oe == 1'b0, "R10 disable wins", pad_oe, 0);
    standby_pin = 1'b0;
    wr(16'h0000);
    @(negedge clk);
    chk(pad_oe == 1'b1, "R9 enabled", pad_oe, 1);
  endtask

  task automatic t_restart(input int t);
    int n = 0;
    integ_time = IW'(t);
    wr(16'h0002);
    chk(restart_pulse == 1'b1, "R4 pulse", restart_pulse, 1);
    chk(rd_data[1] == 1'b0, "R4 reads zero", rd_data[1], 0);
    for (int i = 0; i < 40 && frame_hold; i++) begin
      if (i == 1) chk(restart_pulse == 1'b0, "R4 one cycle", restart_pulse, 0);
      n++;
      @(negedge clk);
    end
    if (t == 0) chk(restart_pulse == 1'b0 || n == 0, "R6 zero", n, 0);
    chk(n == t, "R6 hold length", n, t);
    chk(!frame_hold, "R6 released", frame_hold, 0);
  endtask

  task automatic t_reset_bit();
    wr(16'h001C);
    wr(16'h0001);
    chk(soft_rst && rd_data == 16'h0001, "R2 defaults", rd_data, 1);
    chk(frame_hold == 1'b1, "R6 hold in reset", frame_hold, 1);
    wr(16'h003D);
    chk(rd_data == 16'h0001, "R2 writes dropped", rd_data, 1);
    wr(16'h0003);
    chk(restart_pulse == 1'b0, "R5 ignored in reset", restart_pulse, 0);
    wr(16'h0000);
    chk(!soft_rst && !frame_hold, "R3 cleared", {soft_rst, frame_hold}, 0);
    wr(16'h0014);
    chk(rd_data == 16'h0014, "R3 writable", rd_data, 16'h0014);
    wr(16'h001F);
    chk(rd_data == 16'h0001 && !restart_pulse, "R5 same write", rd_data, 1);
    wr(16'h0000);
    chk(rd_data == 0 && !soft_rst, "R1 clear", rd_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_hard_reset();
    t_spare_standby();
    t_oe();
    t_restart(5);
    t_restart(0);
    t_reset_bit();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule